// File: doc/BRIEF.md
# FIFO-to-Peripheral DMA Strobe Pacer

This block paces a direct memory transfer from an external first-in-first-out buffer into the DMA data port of a peripheral. The FIFO output bus is wired straight to the peripheral's DMA data lines. The block has no address generator and no data path of its own. It drives only the timing strobes: an acknowledge to the peripheral, a read strobe to the FIFO and a write strobe to the peripheral.

The block re-evaluates the grant on every clock. The grant is given when three conditions hold together: the peripheral requests, the FIFO holds data, and software has enabled the block. While the grant holds, one word moves per clock. When the peripheral withdraws its request, or the FIFO runs dry, the strobes stop at once. They restart without host action when the conditions return. The peripheral ends the transfer itself by counting down its own byte count, so the block keeps no terminal count. The block does keep a free-running count of words it has strobed, and software can clear that count.

The FIFO flag is active low and crosses into the transfer clock through a synchronizer of `SYNC_STAGES` flip-flops. At 16 bits per word, a 25 MHz strobe clock carries 50 MB/s.

Top module: `fifo_dma_pacer`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) drives `dma_ack`, `fifo_rd`, `dev_wr` and `word_count` to 0 at that edge. It also clears the synchronizer to the "FIFO empty" state.
- R2: `dma_ack` is 1 after a rising edge exactly when, at that edge, `xfer_en`, `dev_req` and the synchronized FIFO-has-data flag are all 1.
- R3: `fifo_empty_n` is active low (0 means empty) and passes through 2 synchronizer stages. A value sampled at edge k therefore takes part in the grant at edge k+2, and it shows on `dma_ack` after that edge.
- R4: `fifo_rd` and `dev_wr` are equal to `dma_ack` in every cycle. This gives one word per clock while granted.
- R5: If `dev_req` is 0 at an edge, all three strobes are 0 after that edge.
- R6: If `xfer_en` is 0 at an edge, all three strobes are 0 after that edge, whatever the other inputs are.
- R7: At an edge where `cnt_clr` is 0, `word_count` increases by 1 if `fifo_rd` was 1 before the edge. Otherwise it holds.
- R8: At an edge where `cnt_clr` is 1, `word_count` becomes 0. The clear takes priority over an increment in the same cycle.
- R9: `word_count` wraps from 2^CNT_W-1 to 0.
- R10: After a pause, the strobes resume by themselves once request, data and enable are all present again, with no other input action.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transfer clock |
| rst | input | 1 | Synchronous reset, active high |
| dev_req | input | 1 | DMA request from the peripheral |
| fifo_empty_n | input | 1 | FIFO empty flag, active low (asynchronous) |
| xfer_en | input | 1 | Software enable for the pacer |
| cnt_clr | input | 1 | Synchronous clear of the word count |
| dma_ack | output | 1 | DMA acknowledge to the peripheral |
| fifo_rd | output | 1 | FIFO read strobe |
| dev_wr | output | 1 | Peripheral DMA write strobe |
| word_count | output | CNT_W | Number of words strobed since the last clear |

## Verification
Request and enable act on the strobes after one edge. A change on `fifo_empty_n` reaches the strobes after three edges: two synchronizer stages plus the grant register. `word_count` trails the strobe by one further edge. The bench drives inputs on the falling edge and compares the outputs on the next falling edge. Its reference model has the same edge counts, and is built from the requirements alone. The bench sweeps every input combination with a small counter width so that wrap is reached, then runs a long pseudo-random sequence.

// File: rtl/fdp_pkg.sv
package fdp_pkg;
  typedef enum logic {
    GATE_HOLD = 1'b0,
    GATE_RUN  = 1'b1
  } gate_e;

  typedef struct packed {
    logic ack;
    logic rd;
    logic wr;
  } strobes_t;
endpackage

// File: rtl/fdp_sync.sv
module fdp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= d_async;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= 1'b0;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/fdp_gate.sv
module fdp_gate
  import fdp_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     enable,
  input  logic     request,
  input  logic     has_data,
  output strobes_t stb,
  output gate_e    state
);
  gate_e    nxt;
  strobes_t stb_q;

  always_comb begin
    nxt = (enable && request && has_data) ? GATE_RUN : GATE_HOLD;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= GATE_HOLD;
      stb_q <= '0;
    end else begin
      state     <= nxt;
      stb_q.ack <= (nxt == GATE_RUN);
      stb_q.rd  <= (nxt == GATE_RUN);
      stb_q.wr  <= (nxt == GATE_RUN);
    end
  end

  assign stb = stb_q;
endmodule

// File: rtl/fdp_counter.sv
module fdp_counter #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             bump,
  output logic [WIDTH-1:0] value
);
  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (rst || clear) value <= '0;
    else if (bump)    value <= value + ONE;
  end
endmodule

// File: rtl/fifo_dma_pacer.sv
module fifo_dma_pacer
  import fdp_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dev_req,
  input  logic             fifo_empty_n,
  input  logic             xfer_en,
  input  logic             cnt_clr,
  output logic             dma_ack,
  output logic             fifo_rd,
  output logic             dev_wr,
  output logic [CNT_W-1:0] word_count
);
  logic     have_data;
  strobes_t stb;
  gate_e    gate_state;

  fdp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async (fifo_empty_n),
    .q_sync  (have_data)
  );

  fdp_gate u_gate (
    .clk      (clk),
    .rst      (rst),
    .enable   (xfer_en),
    .request  (dev_req),
    .has_data (have_data),
    .stb      (stb),
    .state    (gate_state)
  );

  fdp_counter #(.WIDTH(CNT_W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .clear (cnt_clr),
    .bump  (stb.rd),
    .value (word_count)
  );

  assign dma_ack = stb.ack;
  assign fifo_rd = stb.rd;
  assign dev_wr  = stb.wr;
endmodule

// File: rtl/fifo_dma_pacer_chk.sv
module fifo_dma_pacer_chk #(
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             dev_req,
  input logic             fifo_empty_n,
  input logic             xfer_en,
  input logic             cnt_clr,
  input logic             dma_ack,
  input logic             fifo_rd,
  input logic             dev_wr,
  input logic [CNT_W-1:0] word_count
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  AST_STROBES_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    (fifo_rd == dma_ack) && (dev_wr == dma_ack)); // R4
  AST_ACK_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
    dma_ack |-> $past(dev_req)); // R5
  AST_ACK_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    dma_ack |-> $past(xfer_en)); // R6
  AST_ACK_NEEDS_DATA: assert property (@(posedge clk) disable iff (rst)
    dma_ack |-> $past(fifo_empty_n, SYNC_STAGES + 1)); // R3
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (!cnt_clr && fifo_rd) |=> (word_count == $past(word_count) + ONE)); // R7
  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!cnt_clr && !fifo_rd) |=> $stable(word_count)); // R7
  AST_COUNT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    cnt_clr |=> (word_count == '0)); // R8
endmodule

bind fifo_dma_pacer fifo_dma_pacer_chk #(
  .CNT_W       (CNT_W),
  .SYNC_STAGES (SYNC_STAGES)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .dev_req      (dev_req),
  .fifo_empty_n (fifo_empty_n),
  .xfer_en      (xfer_en),
  .cnt_clr      (cnt_clr),
  .dma_ack      (dma_ack),
  .fifo_rd      (fifo_rd),
  .dev_wr       (dev_wr),
  .word_count   (word_count)
);

// File: tb/fifo_dma_pacer_tb.sv
module fifo_dma_pacer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W          = 6;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         dev_req = 1'b0;
  logic         fifo_empty_n = 1'b0;
  logic         xfer_en = 1'b0;
  logic         cnt_clr = 1'b0;
  logic         dma_ack, fifo_rd, dev_wr;
  logic [W-1:0] word_count;

  int tests = 0;
  int fails = 0;

  // reference model state
  logic         m_s1 = 1'b0, m_s2 = 1'b0, m_ack = 1'b0;
  logic [W-1:0] m_cnt = '0;
  string        ack_tag = "R2";

  always #(CLK_PERIOD/2) clk = ~clk;

  fifo_dma_pacer #(.CNT_W(W), .SYNC_STAGES(2)) u_dut (
    .clk          (clk),
    .rst          (rst),
    .dev_req      (dev_req),
    .fifo_empty_n (fifo_empty_n),
    .xfer_en      (xfer_en),
    .cnt_clr      (cnt_clr),
    .dma_ack      (dma_ack),
    .fifo_rd      (fifo_rd),
    .dev_wr       (dev_wr),
    .word_count   (word_count)
  );

  // Model from requirements; inputs are stable at the rising edge.
  always @(posedge clk) begin
    if (rst) begin
      m_s1 <= 1'b0; m_s2 <= 1'b0; m_ack <= 1'b0; m_cnt <= '0;
    end else begin
      m_s1  <= fifo_empty_n;
      m_s2  <= m_s1;
      m_ack <= xfer_en && dev_req && m_s2;
      m_cnt <= cnt_clr ? '0 : (m_cnt + W'(m_ack));
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk(ack_tag, 32'(dma_ack), 32'(m_ack));
    chk("R4 rd", 32'(fifo_rd), 32'(m_ack));
    chk("R4 wr", 32'(dev_wr), 32'(m_ack));
    chk((m_cnt == '0) ? "R8/R9 count" : "R7 count", 32'(word_count), 32'(m_cnt));
  endtask

  task automatic step(input logic e, input logic r, input logic f, input logic c);
    @(negedge clk);
    check_all();
    xfer_en = e; dev_req = r; fifo_empty_n = f; cnt_clr = c;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    int          stalled;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk("R1 ack", 32'(dma_ack), 0);
    chk("R1 rd", 32'(fifo_rd), 0);
    chk("R1 wr", 32'(dev_wr), 0);
    chk("R1 count", 32'(word_count), 0);

    // exhaustive sweep over input combinations, held several cycles
    ack_tag = "R2";
    for (int pass = 0; pass < 3; pass++)
      for (int v = 0; v < 16; v++)
        for (int k = 0; k < 5; k++)
          step(v[0], v[1], v[2], v[3] & (k == 4));

    // R3: flag latency, data present then empty while request held
    ack_tag = "R3";
    for (int k = 0; k < 6; k++) step(1, 1, 1, 0);
    for (int k = 0; k < 6; k++) step(1, 1, 0, 0);
    @(negedge clk); chk("R3 stopped", 32'(dma_ack), 0);

    // R5: request drop stops strobes next edge; R10: auto resume
    for (int k = 0; k < 5; k++) step(1, 1, 1, 0);
    ack_tag = "R5"; step(1, 0, 1, 0);
    @(negedge clk); chk("R5 paused", 32'(fifo_rd), 0);
    ack_tag = "R10"; dev_req = 1'b1;
    @(negedge clk); chk("R10 resumed", 32'(dev_wr), 1);

    // R6: enable low dominates
    ack_tag = "R6";
    for (int k = 0; k < 4; k++) step(0, 1, 1, 0);
    chk("R6 off", 32'(dma_ack), 0);

    // R8: clear together with an active strobe
    for (int k = 0; k < 4; k++) step(1, 1, 1, 0);
    step(1, 1, 1, 1);
    @(negedge clk); chk("R8 clear wins", 32'(word_count), 0);
    cnt_clr = 1'b0;

    // R9: run long enough to wrap the counter
    ack_tag = "R9";
    for (int k = 0; k < 3 * (1 << W); k++) step(1, 1, 1, 0);

    // pseudo-random stream
    ack_tag = "R2";
    lfsr = 16'hACE1;
    stalled = 0;
    for (int k = 0; k < 4000; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0] | lfsr[1], lfsr[2] | lfsr[3], lfsr[4] | lfsr[5] | lfsr[6],
           (lfsr[11:7] == 5'd0));
    end
    step(0, 0, 0, 0);
    @(negedge clk); check_all();

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule